// File: doc/BRIEF.md
# Overlapping Composite Register File

This block stores twenty-six byte-wide general registers, indexed 0 (A) through 25 (Z). No register has a special role. Any port may address any register, either alone or as the first of a run of two, three or four consecutive registers. A run forms a 16-, 24- or 32-bit value. The register after Z is A, so wide views may start anywhere and neighbouring views share bytes. The even-aligned pairs are simply a subset of the same scheme and use the same storage.

Each cycle the block serves two independent read ports and one write port. Every port carries a starting register index and a 2-bit width code. Reads are combinational and return the composed value zero-extended onto a 32-bit bus. A write splits its data into bytes and updates exactly the addressed run of registers on the rising clock edge. Instruction decoding, arithmetic and memory live outside this block.

Top module: `wreg_file`

## Requirements
- R1: After reset every register holds zero, so every valid read returns 0.
- R2: A read with width code 2'b00 returns the addressed register in bits 7:0 and zero in bits 31:8.
- R3: Width codes 2'b01, 2'b10 and 2'b11 select a run of N = 2, 3 and 4 registers. The starting register appears in bits 8N-1:8N-8, each later register sits one byte lower, and bits 31:8N are zero.
- R4: Register indices wrap modulo 26 for reads and for writes, so a run that starts at index 25 continues at index 0.
- R5: A write with width code w and start s stores the low 8N bits of the write data into registers s to s+N-1 (modulo 26). The most significant of those bytes goes to register s.
- R6: A write changes exactly N registers and leaves every other register unchanged.
- R7: A write takes effect at the rising clock edge. A read of a register that is written in the same cycle returns the old value.
- R8: The two read ports are independent: each returns its own view for any start index and width in the same cycle.
- R9: A start index of 26 to 31 on the write port changes no register. The same range on a read port returns zero.
- R10: With the write enable low, no register changes, whatever the write data, index or width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd0_idx | input | 5 | Read port 0 starting register index |
| rd0_wd | input | 2 | Read port 0 width code |
| rd0_data | output | 32 | Read port 0 composed value, zero-extended |
| rd1_idx | input | 5 | Read port 1 starting register index |
| rd1_wd | input | 2 | Read port 1 width code |
| rd1_data | output | 32 | Read port 1 composed value, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write starting register index |
| wr_wd | input | 2 | Write width code |
| wr_data | input | 32 | Write data; only the low 8N bits are used |

## Verification
The bench targets runs that cross from Z back to A. A design that does not wrap would read or write beyond the array, or would clip the view. It checks byte order in both directions, since a swapped composition shows up as mirrored values in 16- and 32-bit reads. Full-register sweeps after narrow and wide writes catch a decoder that touches one register too many, or one too few. Reads of a register in the same cycle it is written, disabled writes carrying data, and start indices 26 to 31 expose write-through bypasses, ignored enables, and out-of-range writes that alias onto real registers.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  localparam int unsigned REG_COUNT_DEF = 26;
  localparam int unsigned BYTE_W_DEF    = 8;
  localparam int unsigned MAX_BYTES_DEF = 4;

  typedef enum logic [1:0] {
    VIEW_8  = 2'b00,
    VIEW_16 = 2'b01,
    VIEW_24 = 2'b10,
    VIEW_32 = 2'b11
  } view_width_e;
endpackage

// File: rtl/wreg_rst_sync.sv
module wreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wreg_lane_map.sv
module wreg_lane_map #(
  parameter int unsigned REG_COUNT = wreg_pkg::REG_COUNT_DEF,
  parameter int unsigned MAX_BYTES = wreg_pkg::MAX_BYTES_DEF,
  localparam int unsigned IDX_W    = $clog2(REG_COUNT + 1)
) (
  input  logic [IDX_W-1:0]                start_i,
  output logic [MAX_BYTES-1:0][IDX_W-1:0] lane_idx_o,
  output logic                            start_ok_o
);
  localparam logic [IDX_W:0] COUNT_X = (IDX_W+1)'(REG_COUNT);

  assign start_ok_o = ({1'b0, start_i} < COUNT_X);

  // Lane k addresses register (start + k) folded once back into range.
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    logic [IDX_W:0] raw;
    logic [IDX_W:0] folded;
    assign raw    = {1'b0, start_i} + (IDX_W+1)'(k);
    assign folded = raw - COUNT_X;
    assign lane_idx_o[k] = IDX_W'((raw >= COUNT_X) ? folded : raw);
  end
endmodule

// File: rtl/wreg_read_port.sv
module wreg_read_port #(
  parameter int unsigned REG_COUNT = wreg_pkg::REG_COUNT_DEF,
  parameter int unsigned BYTE_W    = wreg_pkg::BYTE_W_DEF,
  parameter int unsigned MAX_BYTES = wreg_pkg::MAX_BYTES_DEF,
  localparam int unsigned IDX_W    = $clog2(REG_COUNT + 1),
  localparam int unsigned WD_W     = $clog2(MAX_BYTES),
  localparam int unsigned BUS_W    = BYTE_W * MAX_BYTES
) (
  input  logic [REG_COUNT-1:0][BYTE_W-1:0] regs_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [WD_W-1:0]                  wd_i,
  output logic [BUS_W-1:0]                 data_o
);
  logic [MAX_BYTES-1:0][IDX_W-1:0] lane_idx;
  logic                            start_ok;

  wreg_lane_map #(
    .REG_COUNT (REG_COUNT),
    .MAX_BYTES (MAX_BYTES)
  ) lane_map_i (
    .start_i    (idx_i),
    .lane_idx_o (lane_idx),
    .start_ok_o (start_ok)
  );

  // Lane 0 lands in the most significant used byte; the rest step downwards.
  always_comb begin
    data_o = '0;
    if (start_ok) begin
      for (int k = 0; k < int'(MAX_BYTES); k++) begin
        if (k <= int'(wd_i)) begin
          data_o[(int'(wd_i) - k) * BYTE_W +: BYTE_W] = regs_i[lane_idx[k]];
        end
      end
    end
  end
endmodule

// File: rtl/wreg_write_decode.sv
module wreg_write_decode #(
  parameter int unsigned REG_COUNT = wreg_pkg::REG_COUNT_DEF,
  parameter int unsigned BYTE_W    = wreg_pkg::BYTE_W_DEF,
  parameter int unsigned MAX_BYTES = wreg_pkg::MAX_BYTES_DEF,
  localparam int unsigned IDX_W    = $clog2(REG_COUNT + 1),
  localparam int unsigned WD_W     = $clog2(MAX_BYTES),
  localparam int unsigned BUS_W    = BYTE_W * MAX_BYTES
) (
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [WD_W-1:0]                  wd_i,
  input  logic [BUS_W-1:0]                 data_i,
  output logic [REG_COUNT-1:0]             we_o,
  output logic [REG_COUNT-1:0][BYTE_W-1:0] wbyte_o
);
  logic [MAX_BYTES-1:0][IDX_W-1:0] lane_idx;
  logic                            start_ok;

  wreg_lane_map #(
    .REG_COUNT (REG_COUNT),
    .MAX_BYTES (MAX_BYTES)
  ) lane_map_i (
    .start_i    (idx_i),
    .lane_idx_o (lane_idx),
    .start_ok_o (start_ok)
  );

  // MAX_BYTES < REG_COUNT, so two lanes never hit the same register.
  always_comb begin
    we_o    = '0;
    wbyte_o = '0;
    if (wr_en_i && start_ok) begin
      for (int k = 0; k < int'(MAX_BYTES); k++) begin
        if (k <= int'(wd_i)) begin
          we_o[lane_idx[k]]    = 1'b1;
          wbyte_o[lane_idx[k]] = data_i[(int'(wd_i) - k) * BYTE_W +: BYTE_W];
        end
      end
    end
  end
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int unsigned REG_COUNT = wreg_pkg::REG_COUNT_DEF,
  parameter int unsigned BYTE_W    = wreg_pkg::BYTE_W_DEF,
  parameter int unsigned MAX_BYTES = wreg_pkg::MAX_BYTES_DEF,
  localparam int unsigned IDX_W    = $clog2(REG_COUNT + 1),
  localparam int unsigned WD_W     = $clog2(MAX_BYTES),
  localparam int unsigned BUS_W    = BYTE_W * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [WD_W-1:0]  rd0_wd,
  output logic [BUS_W-1:0] rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [WD_W-1:0]  rd1_wd,
  output logic [BUS_W-1:0] rd1_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WD_W-1:0]  wr_wd,
  input  logic [BUS_W-1:0] wr_data
);
  logic                             rst_sync_n;
  logic [REG_COUNT-1:0]             wr_we;
  logic [REG_COUNT-1:0][BYTE_W-1:0] wr_byte;
  logic [REG_COUNT-1:0][BYTE_W-1:0] regs_q;
  logic [REG_COUNT-1:0][BYTE_W-1:0] regs_d;

  wreg_rst_sync #(
    .STAGES (2)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wreg_write_decode #(
    .REG_COUNT (REG_COUNT),
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES)
  ) wr_dec_i (
    .wr_en_i (wr_en),
    .idx_i   (wr_idx),
    .wd_i    (wr_wd),
    .data_i  (wr_data),
    .we_o    (wr_we),
    .wbyte_o (wr_byte)
  );

  // One byte register per entry with its own clock enable.
  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    always_comb begin
      regs_d[r] = wr_we[r] ? wr_byte[r] : regs_q[r];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        regs_q[r] <= '0;
      end else if (wr_we[r]) begin
        regs_q[r] <= regs_d[r];
      end
    end
  end

  wreg_read_port #(
    .REG_COUNT (REG_COUNT),
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES)
  ) rd0_i (
    .regs_i (regs_q),
    .idx_i  (rd0_idx),
    .wd_i   (rd0_wd),
    .data_o (rd0_data)
  );

  wreg_read_port #(
    .REG_COUNT (REG_COUNT),
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES)
  ) rd1_i (
    .regs_i (regs_q),
    .idx_i  (rd1_idx),
    .wd_i   (rd1_wd),
    .data_o (rd1_data)
  );
endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
  parameter int unsigned REG_COUNT = wreg_pkg::REG_COUNT_DEF,
  parameter int unsigned BYTE_W    = wreg_pkg::BYTE_W_DEF,
  parameter int unsigned MAX_BYTES = wreg_pkg::MAX_BYTES_DEF,
  localparam int unsigned IDX_W    = $clog2(REG_COUNT + 1),
  localparam int unsigned WD_W     = $clog2(MAX_BYTES),
  localparam int unsigned BUS_W    = BYTE_W * MAX_BYTES
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [IDX_W-1:0]                 rd0_idx,
  input logic [WD_W-1:0]                  rd0_wd,
  input logic [BUS_W-1:0]                 rd0_data,
  input logic [IDX_W-1:0]                 rd1_idx,
  input logic [BUS_W-1:0]                 rd1_data,
  input logic                             wr_en,
  input logic [IDX_W-1:0]                 wr_idx,
  input logic [WD_W-1:0]                  wr_wd,
  input logic [BUS_W-1:0]                 wr_data,
  input logic [REG_COUNT-1:0]             we,
  input logic [REG_COUNT-1:0][BYTE_W-1:0] regs_q
);
  localparam logic [IDX_W-1:0] COUNT_I = IDX_W'(REG_COUNT);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(REG_COUNT - 1);

  // R6
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < COUNT_I) |-> ($countones(we) == int'(wr_wd) + 1));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(regs_q));

  // R9
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= COUNT_I) |=> $stable(regs_q));

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_keep
    // R6
    keep_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we[r]) |=> (regs_q[r] == $past(regs_q[r])));
  end

  // R5
  byte_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wd == 2'b00 && wr_idx < COUNT_I)
      |=> (regs_q[$past(wr_idx)] == $past(wr_data[BYTE_W-1:0])));

  // R2
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_wd == 2'b00) |-> (rd0_data[BUS_W-1:BYTE_W] == '0));

  // R4
  wrap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == LAST_I && rd0_wd == 2'b01)
      |-> (rd0_data[BYTE_W-1:0] == regs_q[0] && rd0_data[2*BYTE_W-1:BYTE_W] == regs_q[REG_COUNT-1]));

  // R9
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_idx >= COUNT_I) |-> (rd1_data == '0));
endmodule

bind wreg_file wreg_file_chk #(
  .REG_COUNT (REG_COUNT),
  .BYTE_W    (BYTE_W),
  .MAX_BYTES (MAX_BYTES)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rd0_idx  (rd0_idx),
  .rd0_wd   (rd0_wd),
  .rd0_data (rd0_data),
  .rd1_idx  (rd1_idx),
  .rd1_data (rd1_data),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_wd    (wr_wd),
  .wr_data  (wr_data),
  .we       (wr_we),
  .regs_q   (regs_q)
);

// File: tb/wreg_file_tb.sv
module wreg_file_tb_top;
  localparam int NREG = 26;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rd0_idx, rd1_idx, wr_idx;
  logic [1:0]  rd0_wd, rd1_wd, wr_wd;
  logic [31:0] rd0_data, rd1_data, wr_data;
  logic        wr_en;

  int checks;
  int errors;
  bit done;
  int model [NREG];

  wreg_file dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_idx  (rd0_idx),
    .rd0_wd   (rd0_wd),
    .rd0_data (rd0_data),
    .rd1_idx  (rd1_idx),
    .rd1_wd   (rd1_wd),
    .rd1_data (rd1_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_wd    (wr_wd),
    .wr_data  (wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_read(int idx, int wd);
    logic [31:0] v;
    v = '0;
    if (idx < NREG) begin
      for (int k = 0; k <= wd; k++) begin
        v = (v << 8) | 32'(model[(idx + k) % NREG] & 8'hff);
      end
    end
    return v;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare reads, then let the edge commit.
  task automatic step(string tag, bit we, int wi, int ww, logic [31:0] wd,
                      int i0, int w0, int i1, int w1);
    @(negedge clk);
    wr_en   = we;
    wr_idx  = 5'(wi);
    wr_wd   = 2'(ww);
    wr_data = wd;
    rd0_idx = 5'(i0);
    rd0_wd  = 2'(w0);
    rd1_idx = 5'(i1);
    rd1_wd  = 2'(w1);
    #1;
    check(tag, $sformatf("rd0 idx=%0d wd=%0d", i0, w0), rd0_data, exp_read(i0, w0));
    check(tag, $sformatf("rd1 idx=%0d wd=%0d", i1, w1), rd1_data, exp_read(i1, w1));
    @(posedge clk);
    if (we && wi < NREG) begin
      for (int k = 0; k <= ww; k++) begin
        model[(wi + k) % NREG] = int'((wd >> (8 * (ww - k))) & 32'hff);
      end
    end
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < NREG; r += 2) begin
      step(tag, 1'b0, 0, 0, 32'h0, r, 0, r + 1, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    for (int r = 0; r < NREG; r++) model[r] = 0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_wd = '0; wr_data = '0;
    rd0_idx = '0; rd0_wd = '0; rd1_idx = '0; rd1_wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset contents, narrow and wide views
    sweep("R1");
    step("R1", 1'b0, 0, 0, 32'h0, 0, 3, 22, 3);

    // R2 / R5: fill each register alone
    for (int r = 0; r < NREG; r++) begin
      step("R5", 1'b1, r, 0, 32'hABCD_EF00 | 32'((r * 37 + 11) & 8'hff), r, 0, (r + 25) % NREG, 0);
    end
    sweep("R2");

    // R3: byte order of 16, 24 and 32-bit views
    step("R3", 1'b1, 0, 1, 32'hDEAD_1234, 0, 3, 1, 2);
    step("R3", 1'b0, 0, 0, 32'h0, 0, 1, 0, 3);
    step("R3", 1'b1, 4, 2, 32'hFF_5A6B7C, 3, 3, 4, 2);
    step("R3", 1'b0, 0, 0, 32'h0, 4, 2, 5, 1);

    // R4: wide write starting at Z wraps onto A, B, C
    step("R4", 1'b1, 25, 3, 32'h1122_3344, 24, 3, 25, 1);
    step("R4", 1'b0, 0, 0, 32'h0, 25, 3, 23, 3);
    step("R4", 1'b0, 0, 0, 32'h0, 25, 1, 0, 2);
    // R6: everything outside Z..C kept
    sweep("R6");

    // R7: read of the register being written returns the old value
    step("R7", 1'b1, 10, 1, 32'h0000_9988, 10, 1, 11, 0);
    step("R7", 1'b1, 10, 1, 32'h0000_7766, 10, 1, 9, 3);
    step("R7", 1'b0, 0, 0, 32'h0, 10, 1, 11, 0);

    // R10: disabled write with live data changes nothing
    step("R10", 1'b0, 12, 3, 32'hCAFE_F00D, 12, 3, 14, 1);
    step("R10", 1'b0, 0, 0, 32'h0, 12, 3, 14, 1);

    // R9: start index past Z
    for (int i = 26; i < 32; i++) begin
      step("R9", 1'b1, i, 3, 32'h5555_AAAA, i, 3, 0, 3);
    end
    step("R9", 1'b0, 0, 0, 32'h0, 30, 0, 31, 1);
    sweep("R9");

    // R8: independent ports under mixed traffic
    for (int n = 0; n < 400; n++) begin
      int i0, i1, wi;
      i0 = int'($urandom_range(0, 31));
      i1 = int'($urandom_range(0, 27));
      wi = int'($urandom_range(0, 27));
      step("R8", 1'($urandom_range(0, 1)), wi, int'($urandom_range(0, 3)), $urandom(),
           i0, int'($urandom_range(0, 3)), i1, int'($urandom_range(0, 3)));
    end
    sweep("R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule